// File: doc/BRIEF.md
# Floating-Point Trivial-Operation Simplifier

This unit sits in front of a single-precision floating-point pipeline. It receives one operation at a time: an opcode, two operands and a valid flag for each operand. It then decides whether the operation can skip the full arithmetic units. An operation is bypassed when its result is simply zero, one, or one of its inputs. It is simplified when a power-of-two operand lets the result be formed by exponent arithmetic alone. Every other operation is marked for the full unit. NaN, infinity and denormal inputs always go to the full unit.

The unit does not have to wait for both operands. A multiply or divide whose zero operand already fixes the result finishes as soon as that operand is valid. Otherwise the unit captures whatever operands have arrived and waits in a holding state until the missing ones come in. The state machine has three states:
- IDLE accepts a request.
- HOLD collects late operands.
- EMIT presents the result for one cycle.

Its transitions are:
- IDLE→EMIT: the request is decided on arrival.
- IDLE→HOLD: operands are missing.
- HOLD→HOLD: still missing.
- HOLD→EMIT: decided.
- EMIT→IDLE: always.

Top module: `fts_simplifier`

## Requirements
- R1: After reset `res_vld` is 0 and `ready` is 1.
- R2: `ready` is high only in IDLE, and `start` is accepted only then. A request that can be decided from the operands valid at acceptance raises `res_vld` for exactly one cycle after the accepting edge. `ready` is low while `res_vld` is high. Opcodes are 0 add, 1 subtract (a−b), 2 multiply, 3 divide (a÷b), 4 absolute value of a, 5 square root of a, and 6–7 unused. `kind` codes are 0 full unit, 1 bypassed, 2 simplified.
- R3: Add with one zero operand returns the other operand (bypassed). When both operands are zero, it returns zero whose sign is the AND of the two signs.
- R4: Subtract with bit-identical operands returns +0. Subtract with a zero subtrahend returns the minuend. Both are bypassed.
- R5: Multiply with a zero operand, or divide with a zero dividend, returns zero whose sign is the XOR of the operand signs (bypassed). Both signs +0 and −0 count as zero.
- R6: Divide with bit-identical operands returns 1.0 (0x3F800000), bypassed.
- R7: Absolute value of a zero or a positive input returns the input, bypassed. A negative non-zero input goes to the full unit.
- R8: Square root of zero returns the input, bypassed. Square root of a positive power of two with an even unbiased exponent returns 1.0 × 2^(e/2), simplified.
- R9: Multiply where one operand is a power of two adds that operand's unbiased exponent to the other operand's exponent. Operand a is tried first. Divide by a power of two subtracts the divisor's unbiased exponent from the dividend's exponent. Both are simplified, with sign equal to the XOR of the operand signs. A power of two has a zero fraction and a biased exponent from 1 to 254.
- R10: If the adjusted exponent leaves 1..254, the operation goes to the full unit. The same applies to the square root of an odd power or a negative power of two.
- R11: The following go to the full unit with result 0: a NaN, infinity or denormal operand, divide by zero, any unused opcode, and any valid pair with no trivial form.
- R12: A multiply with one valid zero operand, or a divide with a valid zero dividend, is decided while the other operand is still invalid. Its result is zero with the sign of the zero operand. A request that cannot be decided waits with `res_vld` low. Operands arriving later with their valid flag are captured. The result appears in the cycle after the edge that completes the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, accepted when `ready` |
| op | input | 3 | Opcode (see R2) |
| opa | input | 32 | Operand a |
| opa_ok | input | 1 | Operand a valid this cycle |
| opb | input | 32 | Operand b |
| opb_ok | input | 1 | Operand b valid this cycle |
| ready | output | 1 | Unit idle and able to take a request |
| res_vld | output | 1 | Result valid, one cycle |
| res | output | 32 | Result word (0 when sent to the full unit) |
| kind | output | 2 | 0 full unit, 1 bypassed, 2 simplified |

## Verification
The bench builds the block with the default 8-bit exponent and 23-bit fraction, which puts the real single-precision encodings within reach. These include the limit exponents 1 and 254, the all-ones special exponent, the signed zeros, and the value 1.0. With these widths the bench can push exponent sums just past both ends of the normal range. It can also drive NaN, infinity and denormal patterns exactly as a floating-point unit would see them. Late-operand requests exercise the HOLD state and its capture path alongside the single-operand early decisions.

// File: rtl/fts_pkg.sv
package fts_pkg;
    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_MUL  = 3'd2,
        OP_DIV  = 3'd3,
        OP_ABS  = 3'd4,
        OP_SQRT = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        K_FULL   = 2'd0,
        K_BYPASS = 2'd1,
        K_SIMPLE = 2'd2
    } kind_e;
endpackage

// File: rtl/fts_fdecode.sv
module fts_fdecode #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W,
    localparam int BIAS  = (1 << (EXP_W - 1)) - 1
) (
    input  logic [W-1:0]             val,
    output logic                     zero,
    output logic                     special,
    output logic                     pow2,
    output logic                     sgn,
    output logic [EXP_W-1:0]         expo,
    output logic signed [EXP_W+1:0]  uexp
);
    logic frac_nz;
    logic exp_ones;
    logic exp_zero;

    always_comb begin
        sgn      = val[W-1];
        expo     = val[W-2:FRAC_W];
        frac_nz  = |val[FRAC_W-1:0];
        exp_ones = &expo;
        exp_zero = ~|expo;
        zero     = exp_zero && !frac_nz;
        special  = exp_ones || (exp_zero && frac_nz);
        pow2     = !frac_nz && !exp_zero && !exp_ones;
        uexp     = $signed({2'b00, expo}) - (EXP_W + 2)'(BIAS);
    end
endmodule

// File: rtl/fts_classify.sv
module fts_classify
    import fts_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W,
    localparam int BIAS  = (1 << (EXP_W - 1)) - 1,
    localparam int EMAX  = (1 << EXP_W) - 1
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic         av,
    input  logic [W-1:0] b,
    input  logic         bv,
    output logic         decided,
    output kind_e        kind,
    output logic [W-1:0] res
);
    logic [1:0][W-1:0]            opnd;
    logic [1:0]                   zr, sp, p2, sg;
    logic [1:0][EXP_W-1:0]        ex;
    logic [1:0][EXP_W+1:0]        ue;

    assign opnd[0] = a;
    assign opnd[1] = b;

    for (genvar gi = 0; gi < 2; gi++) begin : g_dec
        fts_fdecode #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dec (
            .val(opnd[gi]), .zero(zr[gi]), .special(sp[gi]), .pow2(p2[gi]),
            .sgn(sg[gi]), .expo(ex[gi]), .uexp(ue[gi])
        );
    end

    localparam logic [W-1:0] ONE = {2'b00, {(EXP_W-1){1'b1}}, {FRAC_W{1'b0}}};

    logic signed [EXP_W+1:0] s_mul_b, s_mul_a, s_div, s_sqrt;
    logic                    both, sx;

    function automatic logic in_rng(input logic signed [EXP_W+1:0] e);
        return (e >= 1) && (e <= EMAX - 1);
    endfunction

    always_comb begin
        both    = av && bv;
        sx      = sg[0] ^ sg[1];
        s_mul_b = $signed({2'b00, ex[1]}) + $signed(ue[0]);
        s_mul_a = $signed({2'b00, ex[0]}) + $signed(ue[1]);
        s_div   = $signed({2'b00, ex[0]}) - $signed(ue[1]);
        s_sqrt  = ($signed(ue[0]) >>> 1) + (EXP_W + 2)'(BIAS);
        decided = 1'b0;
        kind    = K_FULL;
        res     = '0;
        unique case (op)
            OP_ADD: if (both) begin
                decided = 1'b1;
                if (sp[0] || sp[1]) begin
                end else if (zr[0] && zr[1]) begin
                    kind = K_BYPASS; res = {sg[0] & sg[1], {(W-1){1'b0}}};
                end else if (zr[1]) begin
                    kind = K_BYPASS; res = a;
                end else if (zr[0]) begin
                    kind = K_BYPASS; res = b;
                end
            end
            OP_SUB: if (both) begin
                decided = 1'b1;
                if (sp[0] || sp[1]) begin
                end else if (a == b) begin
                    kind = K_BYPASS; res = '0;
                end else if (zr[1]) begin
                    kind = K_BYPASS; res = a;
                end
            end
            OP_MUL: if (both) begin
                decided = 1'b1;
                if (sp[0] || sp[1]) begin
                end else if (zr[0] || zr[1]) begin
                    kind = K_BYPASS; res = {sx, {(W-1){1'b0}}};
                end else if (p2[0] && in_rng(s_mul_b)) begin
                    kind = K_SIMPLE; res = {sx, s_mul_b[EXP_W-1:0], b[FRAC_W-1:0]};
                end else if (p2[1] && in_rng(s_mul_a)) begin
                    kind = K_SIMPLE; res = {sx, s_mul_a[EXP_W-1:0], a[FRAC_W-1:0]};
                end
            end else if (av && zr[0] && !sp[0]) begin
                decided = 1'b1; kind = K_BYPASS; res = {sg[0], {(W-1){1'b0}}};
            end else if (bv && zr[1] && !sp[1]) begin
                decided = 1'b1; kind = K_BYPASS; res = {sg[1], {(W-1){1'b0}}};
            end
            OP_DIV: if (both) begin
                decided = 1'b1;
                if (sp[0] || sp[1] || zr[1]) begin
                end else if (zr[0]) begin
                    kind = K_BYPASS; res = {sx, {(W-1){1'b0}}};
                end else if (a == b) begin
                    kind = K_BYPASS; res = ONE;
                end else if (p2[1] && in_rng(s_div)) begin
                    kind = K_SIMPLE; res = {sx, s_div[EXP_W-1:0], a[FRAC_W-1:0]};
                end
            end else if (av && zr[0] && !sp[0]) begin
                decided = 1'b1; kind = K_BYPASS; res = {sg[0], {(W-1){1'b0}}};
            end
            OP_ABS: if (av) begin
                decided = 1'b1;
                if (!sp[0] && (zr[0] || !sg[0])) begin
                    kind = K_BYPASS; res = a;
                end
            end
            OP_SQRT: if (av) begin
                decided = 1'b1;
                if (sp[0]) begin
                end else if (zr[0]) begin
                    kind = K_BYPASS; res = a;
                end else if (p2[0] && !sg[0] && !ue[0][0]) begin
                    kind = K_SIMPLE; res = {1'b0, s_sqrt[EXP_W-1:0], {FRAC_W{1'b0}}};
                end
            end
            default: decided = 1'b1;
        endcase
    end
endmodule

// File: rtl/fts_simplifier.sv
module fts_simplifier
    import fts_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [2:0]   op,
    input  logic [W-1:0] opa,
    input  logic         opa_ok,
    input  logic [W-1:0] opb,
    input  logic         opb_ok,
    output logic         ready,
    output logic         res_vld,
    output logic [W-1:0] res,
    output logic [1:0]   kind
);
    typedef enum logic [1:0] {ST_IDLE, ST_HOLD, ST_EMIT} state_e;

    state_e       st, st_nx;
    op_e          op_r, v_op;
    logic [W-1:0] a_r, b_r, v_a, v_b, c_res;
    logic         ah, bh, v_av, v_bv, c_dec;
    kind_e        c_kind, kind_r;

    always_comb begin
        if (st == ST_IDLE) begin
            v_op = op_e'(op);
            v_a  = opa;  v_av = opa_ok;
            v_b  = opb;  v_bv = opb_ok;
        end else begin
            v_op = op_r;
            v_a  = ah ? a_r : opa;  v_av = ah || opa_ok;
            v_b  = bh ? b_r : opb;  v_bv = bh || opb_ok;
        end
    end

    fts_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
        .op(v_op), .a(v_a), .av(v_av), .b(v_b), .bv(v_bv),
        .decided(c_dec), .kind(c_kind), .res(c_res)
    );

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (start) st_nx = c_dec ? ST_EMIT : ST_HOLD;
            ST_HOLD: if (c_dec) st_nx = ST_EMIT;
            ST_EMIT: st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_r <= OP_ADD; a_r <= '0; b_r <= '0; ah <= 1'b0; bh <= 1'b0;
            res  <= '0;     kind_r <= K_FULL;
        end else begin
            if ((st == ST_IDLE && start) || st == ST_HOLD) begin
                op_r <= v_op;
                a_r  <= v_a;  ah <= v_av;
                b_r  <= v_b;  bh <= v_bv;
            end
            if (st_nx == ST_EMIT && st != ST_EMIT) begin
                res    <= c_res;
                kind_r <= c_kind;
            end
        end
    end

    always_comb begin
        ready   = (st == ST_IDLE);
        res_vld = (st == ST_EMIT);
        kind    = kind_r;
    end
endmodule

// File: rtl/fts_simplifier_chk.sv
module fts_simplifier_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [2:0]   op,
    input logic [W-1:0] opa,
    input logic         opa_ok,
    input logic         ready,
    input logic         res_vld,
    input logic [W-1:0] res,
    input logic [1:0]   kind
);
    logic early_mul;
    assign early_mul = ready && start && (op == 3'd2) && opa_ok && (opa[W-2:0] == '0)
                       && rst_n;

    // R2: a result is shown for one cycle only
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |=> !res_vld);

    // R2: no new request may be taken while a result is shown
    p_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> !ready);

    // R2: kind code is one of the three defined values
    p_kind_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> (kind != 2'd3));

    // R11: anything sent to the full unit carries a zero result word
    p_full_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && kind == 2'd0) |-> (res == '0));

    // R12: a zero multiplicand alone finishes the multiply next cycle
    p_early_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        early_mul |=> (res_vld && kind != 2'd2 && res[W-2:0] == '0));
endmodule

bind fts_simplifier fts_simplifier_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opa_ok(opa_ok),
    .ready(ready), .res_vld(res_vld), .res(res), .kind(kind)
);

// File: tb/fts_simplifier_bench.sv
module fts_simplifier_bench;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [2:0]   op = '0;
    logic [W-1:0] opa = '0, opb = '0;
    logic         opa_ok = 1'b0, opb_ok = 1'b0;
    logic         ready, res_vld;
    logic [W-1:0] res;
    logic [1:0]   kind;

    fts_simplifier u_fts_simplifier (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opa_ok(opa_ok),
        .opb(opb), .opb_ok(opb_ok), .ready(ready), .res_vld(res_vld), .res(res), .kind(kind)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [W-1:0] r;
        logic [1:0]   k;
        string        tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   cyc   = 0;
    bit   done  = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops and compares
    always @(negedge clk) begin
        if (rst_n && res_vld) begin
            if (q.size() == 0) begin
                check(1'b0, "unexpected result", res, '0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(res == e.r && kind == e.k, e.tag, {res[W-1:2], kind}, {e.r[W-1:2], e.k});
                if (res != e.r) $display("     %s result actual=%h expected=%h", e.tag, res, e.r);
            end
        end
    end

    task automatic issue(input logic [2:0] o, input logic [W-1:0] a, input logic av,
                         input logic [W-1:0] b, input logic bv,
                         input logic [W-1:0] er, input logic [1:0] ek, input string tag);
        @(negedge clk);
        while (!ready) @(negedge clk);
        op = o; opa = a; opa_ok = av; opb = b; opb_ok = bv; start = 1'b1;
        q.push_back('{er, ek, tag});
        @(posedge clk);
        #1;
        start = 1'b0; opa_ok = 1'b0; opb_ok = 1'b0;
    endtask

    task automatic late(input bit is_b, input logic [W-1:0] v);
        if (is_b) begin opb = v; opb_ok = 1'b1; end
        else      begin opa = v; opa_ok = 1'b1; end
        @(posedge clk);
        #1;
        opa_ok = 1'b0; opb_ok = 1'b0;
    endtask

    localparam logic [1:0] KF = 2'd0, KB = 2'd1, KS = 2'd2;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(res_vld == 1'b0, "R1 res_vld after reset", {31'd0, res_vld}, '0);
        check(ready == 1'b1, "R1 ready after reset", {31'd0, ready}, 32'd1);

        issue(3'd0, 32'h40400000, 1, 32'h00000000, 1, 32'h40400000, KB, "R3 add x+0");
        @(negedge clk);
        check(ready == 1'b0, "R2 ready low during result", {31'd0, ready}, '0);
        issue(3'd0, 32'h00000000, 1, 32'hBFC00000, 1, 32'hBFC00000, KB, "R3 add 0+y");
        issue(3'd0, 32'h80000000, 1, 32'h00000000, 1, 32'h00000000, KB, "R3 add -0 + +0");
        issue(3'd1, 32'h40400000, 1, 32'h40400000, 1, 32'h00000000, KB, "R4 sub equal");
        issue(3'd1, 32'h3FC00000, 1, 32'h80000000, 1, 32'h3FC00000, KB, "R4 sub zero subtrahend");
        issue(3'd2, 32'h40400000, 1, 32'h80000000, 1, 32'h80000000, KB, "R5 mul by -0");
        issue(3'd3, 32'h80000000, 1, 32'h40400000, 1, 32'h80000000, KB, "R5 div -0 dividend");
        issue(3'd3, 32'h40400000, 1, 32'h40400000, 1, 32'h3F800000, KB, "R6 div equal");
        issue(3'd4, 32'h3FC00000, 1, 32'h0, 0, 32'h3FC00000, KB, "R7 abs positive");
        issue(3'd4, 32'hBFC00000, 1, 32'h0, 0, 32'h00000000, KF, "R7 abs negative");
        issue(3'd5, 32'h00000000, 1, 32'h0, 0, 32'h00000000, KB, "R8 sqrt zero");
        issue(3'd5, 32'h41800000, 1, 32'h0, 0, 32'h40800000, KS, "R8 sqrt 16");
        issue(3'd5, 32'h3E800000, 1, 32'h0, 0, 32'h3F000000, KS, "R8 sqrt 0.25");
        issue(3'd2, 32'h40400000, 1, 32'h40000000, 1, 32'h40C00000, KS, "R9 mul 3*2");
        issue(3'd2, 32'hC0800000, 1, 32'h3FC00000, 1, 32'hC0C00000, KS, "R9 mul -4*1.5");
        issue(3'd3, 32'h40400000, 1, 32'h40800000, 1, 32'h3F400000, KS, "R9 div 3/4");
        issue(3'd3, 32'h3FC00000, 1, 32'hBF000000, 1, 32'hC0400000, KS, "R9 div 1.5/-0.5");
        issue(3'd2, 32'h7F000000, 1, 32'h40000000, 1, 32'h00000000, KF, "R10 mul overflow");
        issue(3'd3, 32'h00800000, 1, 32'h40000000, 1, 32'h00000000, KF, "R10 div underflow");
        issue(3'd5, 32'h41000000, 1, 32'h0, 0, 32'h00000000, KF, "R10 sqrt odd power");
        issue(3'd5, 32'hC0800000, 1, 32'h0, 0, 32'h00000000, KF, "R10 sqrt negative");
        issue(3'd0, 32'h7F800000, 1, 32'h00000000, 1, 32'h00000000, KF, "R11 add inf");
        issue(3'd2, 32'h7FC00000, 1, 32'h00000000, 1, 32'h00000000, KF, "R11 mul nan*0");
        issue(3'd0, 32'h00000001, 1, 32'h00000000, 1, 32'h00000000, KF, "R11 add denormal");
        issue(3'd3, 32'h40400000, 1, 32'h00000000, 1, 32'h00000000, KF, "R11 div by zero");
        issue(3'd7, 32'h40400000, 1, 32'h00000000, 1, 32'h00000000, KF, "R11 unused opcode");
        issue(3'd0, 32'h40400000, 1, 32'h3FC00000, 1, 32'h00000000, KF, "R11 add no trivial form");
        issue(3'd2, 32'h80000000, 1, 32'h0, 0, 32'h80000000, KB, "R12 early mul a=-0");
        issue(3'd2, 32'h0, 0, 32'h00000000, 1, 32'h00000000, KB, "R12 early mul b=0");
        issue(3'd3, 32'h00000000, 1, 32'h0, 0, 32'h00000000, KB, "R12 early div 0/?");

        issue(3'd0, 32'h40400000, 1, 32'h0, 0, 32'h40400000, KB, "R12 add late b");
        @(negedge clk);
        check(res_vld == 1'b0, "R12 waits for operand", {31'd0, res_vld}, '0);
        late(1'b1, 32'h00000000);

        issue(3'd2, 32'h40400000, 1, 32'h0, 0, 32'h40C00000, KS, "R12 mul late b");
        @(negedge clk);
        @(negedge clk);
        check(res_vld == 1'b0 && ready == 1'b0, "R12 holds two cycles", {30'd0, res_vld, ready}, '0);
        late(1'b1, 32'h40000000);

        issue(3'd5, 32'h0, 0, 32'h0, 0, 32'h3F800000, KS, "R12 sqrt late a");
        @(negedge clk);
        late(1'b0, 32'h3F800000);

        repeat (4) @(negedge clk);
        check(q.size() == 0, "R2 all results delivered", q.size(), '0);
        done = 1'b1;
    end

    initial begin
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) check(1'b0, "watchdog expired", cyc, '0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule